// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block holds the request and in-service state of an eight-line interrupt controller and resolves which line is served next. Each line's pin is compared with the value it had at the previous clock. A rise on an unmasked line records a request. A rise on a masked line is thrown away. A recorded request raises a one-cycle interrupt pulse, unless a line of equal or higher number is already in service. Line 7 has the highest priority and line 0 the lowest.

The processor answers a pulse with an acknowledge strobe. The core then takes the highest-numbered pending request, clears it and presents an 8-bit vector in the following cycle. It marks that line as in service, or, in automatic end-of-interrupt mode, ends service on it at once. When a secondary controller is present and the line is marked as a cascade input, the vector comes from the secondary controller's vector input. An end-of-interrupt command names a line and clears its in-service bit. If requests are still waiting, the highest one is considered again and may raise a new pulse.

The acknowledge path is a two-state machine. ST_IDLE moves to ST_VEC on `ack` (transition ACCEPT). ST_VEC returns to ST_IDLE when no acknowledge follows (transition RELEASE), or stays in ST_VEC on a back-to-back acknowledge (transition REPEAT). `vector_valid` is high exactly in ST_VEC. Pins are expected to be synchronous to `clk`.

Top module: `irq_priority_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_reg`, `isr_reg`, `int_pulse` and `vector_valid` are all zero.
- R2: The bit for line n of `req_reg` is set one cycle after the clock at which `irq_pin[n]` is 1 having been 0 at the clock before. A pin held at 1 records nothing further.
- R3: If `irq_mask[n]` is 1 at the clock where line n rises, the rise is discarded and `req_reg[n]` is not set by it.
- R4: `int_pulse` is 1 for the cycle after a request is recorded on line n, provided that no `isr_reg` bit at position n or above is set in the state that same clock produces.
- R5: On `ack` with `req_reg` nonzero, the highest-numbered set request bit s is cleared. In the next cycle `vector_valid` is 1 and `vector` equals (`vec_base` AND 0xF8) OR s.
- R6: On such an acknowledge with `auto_eoi` = 0, `isr_reg[s]` is set. With `auto_eoi` = 1, `isr_reg[s]` is cleared instead and an end-of-interrupt evaluation (R8) takes place.
- R7: If `slave_present` is 1 and `cascade_map[s]` is 1 at the acknowledge, `vector` is `slave_vector` instead of the R5 value.
- R8: `eoi_valid` clears `isr_reg[eoi_line]`. If `req_reg` is then nonzero with highest bit h, and no `isr_reg` bit at h or above is set, `int_pulse` is 1 in the next cycle.
- R9: `ack` with `req_reg` zero gives `vector` = `vec_base` AND 0xF8 and `vector_valid` = 1 in the next cycle, and it changes neither `req_reg` nor `isr_reg`.
- R10: When events share a clock, the acknowledge selects from `req_reg` as it stood before that clock, so a same-clock rise is only added afterwards. An end-of-interrupt clear wins over an acknowledge set of the same bit, and R4 and R8 judge against the resulting `isr_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | 8 | Interrupt pins, one per line |
| irq_mask | input | 8 | Per-line mask, 1 drops rises |
| vec_base | input | 8 | Vector base, low three bits ignored |
| cascade_map | input | 8 | Lines fed by the secondary controller |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| slave_present | input | 1 | A secondary controller is attached |
| slave_vector | input | 8 | Vector supplied by the secondary controller |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_line | input | 3 | Line the end-of-interrupt applies to |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_pulse | output | 1 | One-cycle interrupt request to the processor |
| vector | output | 8 | Vector captured at the last acknowledge |
| vector_valid | output | 1 | High in the cycle after an acknowledge |
| req_reg | output | 8 | Pending request bits |
| isr_reg | output | 8 | In-service bits |

## Verification
An acknowledge and a fresh pin rise, or an acknowledge and an end-of-interrupt, can land on the same clock. The two are coupled because the acknowledge edits the very request and in-service bits that the other event reads. The bench provokes this directly: it raises line 7 in the cycle of an acknowledge, and it ends service on the same line the acknowledge selects. Random traffic then drives all three strobes freely. Each result is judged against a bench model that applies the R10 order: selection from the old request set, then addition of new rises, then clear-over-set for in-service bits, with the pulse decision taken on the new in-service state.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;

    // Acknowledge response state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_VEC  = 1'b1
    } ack_state_e;

endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] mask,
    output logic [N-1:0] accepted
);

    logic [N-1:0] pin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        assign accepted[g] = pin[g] & ~pin_q[g] & ~mask[g];
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 8,
    parameter int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [LW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = LW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_core_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = 8,
    parameter int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack,
    input  logic          hit,
    input  logic [LW-1:0] sel,
    input  logic [VW-1:0] vec_base,
    input  logic [N-1:0]  cascade_map,
    input  logic          slave_present,
    input  logic [VW-1:0] slave_vector,
    output logic [VW-1:0] vector,
    output logic          vector_valid
);

    localparam logic [VW-1:0] BASE_KEEP = ~VW'(N - 1);

    ack_state_e    state_q, state_d;
    logic [VW-1:0] vec_q, vec_d;
    logic [VW-1:0] base_aligned;

    assign base_aligned = vec_base & BASE_KEEP;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ack)  state_d = ST_VEC;
            ST_VEC:  if (!ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        vec_d = vec_q;
        if (ack) begin
            if (!hit) begin
                vec_d = base_aligned;
            end else if (slave_present && cascade_map[sel]) begin
                vec_d = slave_vector;
            end else begin
                vec_d = base_aligned | VW'(sel);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            vec_q <= vec_d;
        end
    end

    assign vector       = vec_q;
    assign vector_valid = (state_q == ST_VEC);

    // R5
    ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vector_valid);

    // R9
    empty_ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> (vector == ($past(vec_base) & BASE_KEEP)));

endmodule

// File: rtl/irq_priority_core.sv
module irq_priority_core #(
    parameter int N  = 8,
    parameter int VW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           irq_pin,
    input  logic [N-1:0]           irq_mask,
    input  logic [VW-1:0]          vec_base,
    input  logic [N-1:0]           cascade_map,
    input  logic                   auto_eoi,
    input  logic                   slave_present,
    input  logic [VW-1:0]          slave_vector,
    input  logic                   eoi_valid,
    input  logic [$clog2(N)-1:0]   eoi_line,
    input  logic                   ack,
    output logic                   int_pulse,
    output logic [VW-1:0]          vector,
    output logic                   vector_valid,
    output logic [N-1:0]           req_reg,
    output logic [N-1:0]           isr_reg
);

    localparam int LW = $clog2(N);

    logic [N-1:0]  req_q, req_n;
    logic [N-1:0]  isr_q, isr_n;
    logic [N-1:0]  new_req;
    logic [N-1:0]  sel_oh, eoi_oh;
    logic [N-1:0]  isr_set, isr_clr;
    logic [N-1:0]  blocked;
    logic          hit, take, eoi_evt;
    logic [LW-1:0] sel;
    logic          next_any;
    logic [LW-1:0] next_top;
    logic          edge_fire, eoi_fire;
    logic          pulse_q;

    irq_edge_capture #(.N(N)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (irq_pin),
        .mask     (irq_mask),
        .accepted (new_req)
    );

    // selection from the request set as it stood before this clock
    irq_prio_enc #(.N(N), .LW(LW)) u_sel_enc (
        .bits (req_q),
        .any  (hit),
        .idx  (sel)
    );

    assign take    = ack & hit;
    assign sel_oh  = take ? (N'(1) << sel) : '0;
    assign eoi_oh  = eoi_valid ? (N'(1) << eoi_line) : '0;
    assign isr_set = auto_eoi ? '0 : sel_oh;
    assign isr_clr = eoi_oh | (auto_eoi ? sel_oh : '0);
    assign eoi_evt = eoi_valid | (take & auto_eoi);

    assign req_n = (req_q & ~sel_oh) | new_req;
    assign isr_n = (isr_q | isr_set) & ~isr_clr;

    for (genvar g = 0; g < N; g++) begin : g_block
        assign blocked[g] = |isr_n[N-1:g];
    end

    // re-evaluation target after an end-of-interrupt
    irq_prio_enc #(.N(N), .LW(LW)) u_next_enc (
        .bits (req_n),
        .any  (next_any),
        .idx  (next_top)
    );

    assign edge_fire = |(new_req & ~blocked);
    assign eoi_fire  = eoi_evt & next_any & ~blocked[next_top];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            isr_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            req_q   <= req_n;
            isr_q   <= isr_n;
            pulse_q <= edge_fire | eoi_fire;
        end
    end

    irq_ack_fsm #(.N(N), .VW(VW), .LW(LW)) u_ack (
        .clk           (clk),
        .rst_n         (rst_n),
        .ack           (ack),
        .hit           (hit),
        .sel           (sel),
        .vec_base      (vec_base),
        .cascade_map   (cascade_map),
        .slave_present (slave_present),
        .slave_vector  (slave_vector),
        .vector        (vector),
        .vector_valid  (vector_valid)
    );

    assign int_pulse = pulse_q;
    assign req_reg   = req_q;
    assign isr_reg   = isr_q;

    // R2
    req_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(req_q) & ~$past(irq_pin)) == '0));

    // R3
    masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(req_q) & $past(irq_mask)) == '0));

    // R6
    auto_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_eoi |=> ((isr_q & ~$past(isr_q)) == '0));

    // R8
    eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |=> !isr_q[$past(eoi_line)]);

    // R9
    empty_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (req_q == '0) && !eoi_valid) |=> ((isr_q == $past(isr_q))));

endmodule

// File: tb/irq_priority_core_tb.sv
module irq_priority_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_pin = '0, irq_mask = '0, vec_base = 8'h20, cascade_map = '0;
    logic       auto_eoi = 1'b0, slave_present = 1'b0;
    logic [7:0] slave_vector = 8'h00;
    logic       eoi_valid = 1'b0, ack = 1'b0;
    logic [2:0] eoi_line = '0;
    logic       int_pulse, vector_valid;
    logic [7:0] vector, req_reg, isr_reg;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    // model state
    logic [7:0] m_prev = '0, m_req = '0, m_isr = '0, m_vec = '0;
    logic       m_pulse = 1'b0, m_valid = 1'b0;

    always #10 clk = ~clk;

    irq_priority_core u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .irq_mask(irq_mask),
        .vec_base(vec_base), .cascade_map(cascade_map), .auto_eoi(auto_eoi),
        .slave_present(slave_present), .slave_vector(slave_vector),
        .eoi_valid(eoi_valid), .eoi_line(eoi_line), .ack(ack),
        .int_pulse(int_pulse), .vector(vector), .vector_valid(vector_valid),
        .req_reg(req_reg), .isr_reg(isr_reg)
    );

    function automatic int top_bit(input logic [7:0] v);
        int r = -1;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic bit clear_from(input logic [7:0] v, input int pos);
        for (int i = pos; i < 8; i++) if (v[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    task automatic compare_all();
        cmp("R2 req_reg", req_reg, m_req);
        cmp("R6 isr_reg", isr_reg, m_isr);
        cmp("R4 int_pulse", {7'd0, int_pulse}, {7'd0, m_pulse});
        cmp("R5 vector_valid", {7'd0, vector_valid}, {7'd0, m_valid});
        cmp("R7 vector", vector, m_vec);
    endtask

    // one clock: model next state from current inputs, then compare
    task automatic step();
        logic [7:0] nreq, nisr, nvec, rise;
        logic       npulse, nvalid, hitb;
        int         s, h;
        rise   = irq_pin & ~m_prev & ~irq_mask;
        s      = top_bit(m_req);
        hitb   = (s >= 0);
        nreq   = m_req;
        nisr   = m_isr;
        nvec   = m_vec;
        nvalid = ack;
        if (ack && hitb) begin
            nreq[s] = 1'b0;
            if (!auto_eoi) nisr[s] = 1'b1;
            if (slave_present && cascade_map[s]) nvec = slave_vector;
            else nvec = (vec_base & 8'hF8) | 8'(s);
        end else if (ack) begin
            nvec = vec_base & 8'hF8;
        end
        nreq = nreq | rise;
        if (ack && hitb && auto_eoi) nisr[s] = 1'b0;
        if (eoi_valid) nisr[eoi_line] = 1'b0;
        npulse = 1'b0;
        for (int l = 0; l < 8; l++)
            if (rise[l] && clear_from(nisr, l)) npulse = 1'b1;
        if (eoi_valid || (ack && hitb && auto_eoi)) begin
            h = top_bit(nreq);
            if (h >= 0 && clear_from(nisr, h)) npulse = 1'b1;
        end
        @(posedge clk);
        m_prev  = irq_pin;
        m_req   = nreq;
        m_isr   = nisr;
        m_vec   = nvec;
        m_pulse = npulse;
        m_valid = nvalid;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_in();
        ack = 1'b0;
        eoi_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        phase = "R1";
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        phase = "R2";
        irq_pin = 8'h08; step();
        step();                                   // held high: no new request
        phase = "R3";
        irq_mask = 8'h10; irq_pin = 8'h18; step();
        irq_mask = 8'h00; step();
        phase = "R5";
        ack = 1'b1; step(); idle_in();            // selects line 3, vector 0x23
        phase = "R4";
        irq_pin = 8'h5A; step();                  // line 6 fires, line 1 blocked
        phase = "R8";
        ack = 1'b1; step(); idle_in();            // line 6 in service
        eoi_valid = 1'b1; eoi_line = 3'd6; step();
        eoi_line = 3'd3; step(); idle_in();       // line 1 re-raised
        phase = "R7";
        slave_present = 1'b1; cascade_map = 8'h02; slave_vector = 8'h91;
        ack = 1'b1; step(); idle_in();
        phase = "R9";
        ack = 1'b1; step(); idle_in();
        slave_present = 1'b0;
        phase = "R6";
        eoi_valid = 1'b1; eoi_line = 3'd1; irq_pin = 8'h00; step(); idle_in();
        auto_eoi = 1'b1; irq_pin = 8'h05; step();
        ack = 1'b1; step(); idle_in();
        auto_eoi = 1'b0;
        phase = "R10";
        irq_pin = 8'h00; step();
        irq_pin = 8'h80; ack = 1'b1; step();      // ack picks line 0, line 7 added after
        eoi_valid = 1'b1; eoi_line = 3'd7; step(); idle_in();

        phase = "random";
        for (int n = 0; n < 4000; n++) begin
            irq_pin       = irq_pin ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            if ($urandom % 16 == 0) irq_mask = 8'($urandom) & 8'($urandom);
            if ($urandom % 32 == 0) auto_eoi = $urandom % 2 == 0;
            if ($urandom % 32 == 0) begin
                slave_present = $urandom % 2 == 0;
                cascade_map   = 8'($urandom);
                vec_base      = 8'($urandom);
            end
            slave_vector = 8'($urandom);
            ack          = ($urandom % 4 == 0);
            eoi_valid    = ($urandom % 4 == 0);
            eoi_line     = 3'($urandom);
            step();
        end
        idle_in();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule